// File: doc/BRIEF.md
# Service-Sequence Watchdog Timer

A watchdog peripheral driven from a 16-bit register bus and a slow half-second tick. Once software sets the enable bit, a countdown starts from the programmed timeout. The timeout is programmed in half-second units. The countdown is reloaded only when software writes an exact two-word unlock pair to the service register. A pre-timeout interrupt can be armed to fire a chosen number of half-seconds before expiry.

When the count runs out, the block raises one of two reset requests and holds it until system reset. Which one depends on a control bit: an internal chip reset request, or an active-low external reset pin. Software can also request either reset directly. A freeze option pauses the countdown while a low-power input is high. The cause of the most recent system reset is kept in a status register. That register sits on a separate power-on reset, so the record survives the reset the watchdog itself caused.

Top module: `svc_watchdog`

## Requirements
- R1: After power-on and system reset, control (offset 0x0) reads 0x0030 and interrupt control (offset 0x6) reads 0x0000. In the control value, the timeout field [15:8] is 0, bit 4 is 1 and bit 5 is 1. The outputs rest at intRstReq=0, extRstN=1 and intReq=0.
- R2: Control bit 2 is the enable. Writing 1 to it sets it, and a later write of 0 leaves it set until system reset. The write that first sets it loads the countdown with (field[15:8]+1). Each tick then takes one off the count while the block is enabled.
- R3: Writing 0x5555 to the service register (offset 0x2) and then, as the very next service write, 0xAAAA reloads the countdown with (field[15:8]+1).
- R4: The unlock pair is cleared by any other value written to the service register. A 0xAAAA that does not directly follow a 0x5555 does not reload the count. Neither case reloads.
- R5: When control bit 3 is 0, expiry (the count reaching zero on a tick) asserts intRstReq two clock cycles later. intRstReq stays asserted until system reset, and extRstN stays high.
- R6: When control bit 3 is 1, expiry drives extRstN low and holds it low until system reset. intRstReq stays low.
- R7: Interrupt control (offset 0x6) has an enable at bit 15, a status flag at bit 14 and a pre-timeout value in [7:0]. A tick that brings the count to the pre-timeout value sets the flag. Writing 1 to bit 14 clears it. intReq is high while both the flag and the enable are 1.
- R8: Reset status (offset 0x4) bit 1 reads 1 after a system reset that followed a watchdog expiry. It reads 0 after a system reset with no expiry before it.
- R9: Control bit 4 written 0 asserts intRstReq, and control bit 5 written 0 drives extRstN low. Writing 1 to either bit releases that reset.
- R10: Control bit 0 freezes the countdown while lowPower is high. Only the first write to control after reset can change bit 0.
- R11: A new timeout field written while the count runs does not change the current count. It is used from the next reload on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, clears the reset-cause record |
| rstN | input | 1 | System reset, active low, clears all other state |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| tick | input | 1 | One-cycle pulse every half second |
| lowPower | input | 1 | Low-power mode indication |
| intReq | output | 1 | Pre-timeout interrupt request |
| intRstReq | output | 1 | Internal chip reset request, active high |
| extRstN | output | 1 | External reset output, active low |

## Verification
The countdown is hidden, so a wrong count shows up only through expiry timing. Any count error, including a wrong reload, a lost reload or a missed freeze, moves the reset output by whole ticks, and that shift is visible two cycles after the tick that should or should not have expired. Errors in the sticky enable, the write-once freeze bit or the flag-clear logic appear on the very next read of the affected register. A wrong reset-cause record is visible on the first status read after system reset. The bench therefore compares every output and the read data on every cycle against a behavioural model. It also runs timed scenarios whose expiry ticks are known in advance.

// File: rtl/svc_wdt_pkg.sv
package svc_wdt_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int TOUT_W  = 8;
  localparam int CNT_W   = TOUT_W + 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_IRQ  = 4'h6;

  localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

  // control bit positions
  localparam int B_FRZ  = 0;
  localparam int B_EN   = 2;
  localparam int B_ACT  = 3;
  localparam int B_SWN  = 4;
  localparam int B_EXN  = 5;
  localparam int B_TOUT = 8;
  // interrupt control bit positions
  localparam int B_IEN  = 15;
  localparam int B_IFLG = 14;

  typedef struct packed {
    logic reload;
    logic dec;
  } cnt_strb_t;
endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import svc_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cnt_strb_t         strb,
  input  logic [TOUT_W-1:0] loadVal,
  input  logic [TOUT_W-1:0] preVal,
  output logic              expireHit,
  output logic              preHit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             live;

  assign cntNext = cnt - CNT_W'(1);
  assign live    = strb.dec && !strb.reload && (cnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (strb.reload)           cnt <= CNT_W'(loadVal) + CNT_W'(1);
    else if (strb.dec && cnt != '0) cnt <= cntNext;
  end

  assign expireHit = live && (cnt == CNT_W'(1));
  assign preHit    = live && (cntNext == CNT_W'(preVal));

  // R2: without a strobe the count holds
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.reload && !strb.dec) |=> $stable(cnt));
  // R5: an exhausted count never wraps
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !strb.reload) |=> cnt == '0);
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
  input  logic clk,
  input  logic porN,
  input  logic rstN,
  input  logic tmoEvent,
  output logic lastWdt
);
  logic seen;
  logic lowPrev;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      seen    <= 1'b0;
      lastWdt <= 1'b0;
      lowPrev <= 1'b0;
    end else begin
      lowPrev <= !rstN;
      if (!rstN) begin
        if (!lowPrev) begin
          lastWdt <= seen;
          seen    <= 1'b0;
        end
      end else if (tmoEvent) begin
        seen <= 1'b1;
      end
    end
  end

  // R8: the record only changes on the first cycle of a system reset
  a_r8_record_stable: assert property (@(posedge clk) disable iff (!porN)
    (rstN && $past(rstN)) |-> $stable(lastWdt));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import svc_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              tick,
  input  logic              lowPower,
  input  logic              expireHit,
  input  logic              preHit,
  input  logic              lastWdt,
  output cnt_strb_t         strb,
  output logic [TOUT_W-1:0] loadVal,
  output logic [TOUT_W-1:0] preVal,
  output logic              intReq,
  output logic              intRstReq,
  output logic              extRstN
);
  logic [TOUT_W-1:0] tout;
  logic frzEn, frzLocked, en, act, swN, exN;
  logic armed, expInt, expExt;
  logic preEn, preFlag;
  logic wrCtrl, wrSvc, wrIrq;
  logic enLoad, svcLoad;

  assign wrCtrl = wrEn && (addr == OFS_CTRL);
  assign wrSvc  = wrEn && (addr == OFS_SVC);
  assign wrIrq  = wrEn && (addr == OFS_IRQ);

  assign enLoad  = wrCtrl && wdata[B_EN] && !en;
  assign svcLoad = wrSvc && (wdata == KEY_SECOND) && armed;

  always_comb begin
    strb.reload = enLoad || svcLoad;
    strb.dec    = en && tick && !(frzEn && lowPower) && !(expInt || expExt);
    loadVal     = enLoad ? wdata[B_TOUT +: TOUT_W] : tout;
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tout      <= '0;
      frzEn     <= 1'b0;
      frzLocked <= 1'b0;
      en        <= 1'b0;
      act       <= 1'b0;
      swN       <= 1'b1;
      exN       <= 1'b1;
    end else if (wrCtrl) begin
      tout <= wdata[B_TOUT +: TOUT_W];
      act  <= wdata[B_ACT];
      swN  <= wdata[B_SWN];
      exN  <= wdata[B_EXN];
      if (wdata[B_EN]) en <= 1'b1;
      if (!frzLocked) begin
        frzEn     <= wdata[B_FRZ];
        frzLocked <= 1'b1;
      end
    end
  end

  // unlock sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      armed <= 1'b0;
    else if (wrSvc) armed <= (wdata == KEY_FIRST);
  end

  // expiry latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expInt <= 1'b0;
      expExt <= 1'b0;
    end else if (expireHit) begin
      if (act) expExt <= 1'b1;
      else     expInt <= 1'b1;
    end
  end

  // pre-timeout interrupt control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preEn   <= 1'b0;
      preVal  <= '0;
      preFlag <= 1'b0;
    end else begin
      if (wrIrq) begin
        preEn  <= wdata[B_IEN];
        preVal <= wdata[TOUT_W-1:0];
      end
      if (preHit)                     preFlag <= 1'b1;
      else if (wrIrq && wdata[B_IFLG]) preFlag <= 1'b0;
    end
  end

  // registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intRstReq <= 1'b0;
      extRstN   <= 1'b1;
      intReq    <= 1'b0;
    end else begin
      intRstReq <= !swN || expInt;
      extRstN   <= exN && !expExt;
      intReq    <= preFlag && preEn;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[B_TOUT +: TOUT_W] = tout;
        rdata[B_EXN] = exN;
        rdata[B_SWN] = swN;
        rdata[B_ACT] = act;
        rdata[B_EN]  = en;
        rdata[B_FRZ] = frzEn;
      end
      OFS_STAT: rdata[1] = lastWdt;
      OFS_IRQ: begin
        rdata[B_IEN]      = preEn;
        rdata[B_IFLG]     = preFlag;
        rdata[TOUT_W-1:0] = preVal;
      end
      default: rdata = '0;
    endcase
  end

  a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    en |=> en);
  a_r5_int_held: assert property (@(posedge clk) disable iff (!rstN)
    expInt |=> (expInt && intRstReq));
  a_r6_ext_held: assert property (@(posedge clk) disable iff (!rstN)
    expExt |=> (expExt && !extRstN));
  a_r6_one_path: assert property (@(posedge clk) disable iff (!rstN)
    !(expInt && expExt));
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> $past(preEn));
  a_r10_freeze_once: assert property (@(posedge clk) disable iff (!rstN)
    $past(frzLocked) |-> $stable(frzEn));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              tick,
  input  logic              lowPower,
  output logic              intReq,
  output logic              intRstReq,
  output logic              extRstN
);
  cnt_strb_t         strb;
  logic [TOUT_W-1:0] loadVal;
  logic [TOUT_W-1:0] preVal;
  logic              expireHit;
  logic              preHit;
  logic              lastWdt;

  wdt_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .lowPower(lowPower),
    .expireHit(expireHit), .preHit(preHit), .lastWdt(lastWdt),
    .strb(strb), .loadVal(loadVal), .preVal(preVal),
    .intReq(intReq), .intRstReq(intRstReq), .extRstN(extRstN)
  );

  wdt_countdown u_count (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .preVal(preVal), .expireHit(expireHit), .preHit(preHit)
  );

  wdt_cause u_cause (
    .clk(clk), .porN(porN), .rstN(rstN), .tmoEvent(expireHit),
    .lastWdt(lastWdt)
  );
endmodule

// File: tb/svc_watchdog_tb.sv
module svc_watchdog_tb;
  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, tick = 1'b0, lowPower = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic intReq, intRstReq, extRstN;
  int checks = 0, errors = 0;
  string reqTag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  svc_watchdog u_dut (
    .clk(clk), .porN(porN), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .lowPower(lowPower),
    .intReq(intReq), .intRstReq(intRstReq), .extRstN(extRstN)
  );

  // behavioural reference model
  logic [7:0] mTout, mPv;
  logic [8:0] mCnt;
  logic mFrz, mFrzLk, mEn, mAct, mSw, mEx, mArm, mExI, mExE;
  logic mPf, mPe, mOr, mOe, mOi, mSeen, mLast, mLowPrev;

  function automatic bit mEnLoad();
    return wrEn && addr == 4'h0 && wdata[2] && !mEn;
  endfunction
  function automatic bit mSvcLoad();
    return wrEn && addr == 4'h2 && wdata == 16'hAAAA && mArm;
  endfunction
  function automatic bit mDec();
    return mEn && tick && !(mFrz && lowPower) && !(mExI || mExE);
  endfunction
  function automatic bit mLive();
    return mDec() && !(mEnLoad() || mSvcLoad()) && mCnt != 0;
  endfunction
  function automatic bit mExp();
    return mLive() && mCnt == 9'd1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTout <= 0; mPv <= 0; mCnt <= 0; mFrz <= 0; mFrzLk <= 0; mEn <= 0;
      mAct <= 0; mSw <= 1; mEx <= 1; mArm <= 0; mExI <= 0; mExE <= 0;
      mPf <= 0; mPe <= 0; mOr <= 0; mOe <= 1; mOi <= 0;
    end else begin
      mOr <= !mSw || mExI;
      mOe <= mEx && !mExE;
      mOi <= mPf && mPe;
      if (mEnLoad()) mCnt <= {1'b0, wdata[15:8]} + 9'd1;
      else if (mSvcLoad()) mCnt <= {1'b0, mTout} + 9'd1;
      else if (mDec() && mCnt != 0) mCnt <= mCnt - 9'd1;
      if (mExp()) begin
        if (mAct) mExE <= 1; else mExI <= 1;
      end
      if (mLive() && mCnt - 9'd1 == {1'b0, mPv}) mPf <= 1;
      else if (wrEn && addr == 4'h6 && wdata[14]) mPf <= 0;
      if (wrEn && addr == 4'h6) begin mPe <= wdata[15]; mPv <= wdata[7:0]; end
      if (wrEn && addr == 4'h2) mArm <= (wdata == 16'h5555);
      if (wrEn && addr == 4'h0) begin
        mTout <= wdata[15:8]; mAct <= wdata[3]; mSw <= wdata[4]; mEx <= wdata[5];
        if (wdata[2]) mEn <= 1;
        if (!mFrzLk) begin mFrz <= wdata[0]; mFrzLk <= 1; end
      end
    end
  end

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mSeen <= 0; mLast <= 0; mLowPrev <= 0;
    end else begin
      mLowPrev <= !rstN;
      if (!rstN) begin
        if (!mLowPrev) begin mLast <= mSeen; mSeen <= 0; end
      end else if (mExp()) mSeen <= 1;
    end
  end

  function automatic logic [15:0] mRead(logic [3:0] a);
    case (a)
      4'h0: return {mTout, 2'b00, mEx, mSw, mAct, mEn, 1'b0, mFrz};
      4'h4: return {14'h0, mLast, 1'b0};
      4'h6: return {mPe, mPf, 6'h0, mPv};
      default: return 16'h0;
    endcase
  endfunction

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (porN && !done) begin
      checks++;
      if (rdata !== mRead(addr) || intRstReq !== mOr || extRstN !== mOe || intReq !== mOi) begin
        errors++;
        $display("FAIL %s cycle compare: rd=%h/%h rst=%b/%b ext=%b/%b irq=%b/%b",
                 reqTag, rdata, mRead(addr), intRstReq, mOr, extRstN, mOe, intReq, mOi);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1; addr = a; wdata = d;
    @(negedge clk); wrEn = 0; wdata = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic tk(int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic sysReset();
    @(negedge clk); rstN = 0;
    cyc(3);
    rstN = 1;
    cyc(1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    summary();
  end

  initial begin
    logic [15:0] v;
    cyc(3); porN = 1; cyc(2); rstN = 1; cyc(2);

    // R1 reset state
    reqTag = "R1";
    rd(4'h0, v); chk("R1 ctrl reset", v, 16'h0030);
    rd(4'h6, v); chk("R1 irq reset", v, 16'h0000);
    chk("R1 outputs", {15'h0, intRstReq}, 16'h0);
    chk("R1 ext", {15'h0, extRstN}, 16'h1);

    // R2 enable, sticky; count = 4 ticks
    reqTag = "R2";
    wr(4'h0, 16'h0334);
    wr(4'h0, 16'h0330);
    rd(4'h0, v); chk("R2 enable sticky", v, 16'h0334);
    tk(3);

    // R3 good service sequence reloads
    reqTag = "R3";
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tk(3); cyc(2);
    chk("R3 no expiry after reload", {15'h0, intRstReq}, 16'h0);

    // R7 pre-timeout
    reqTag = "R7";
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    wr(4'h6, 16'h8002);
    tk(2); cyc(2);
    chk("R7 irq raised", {15'h0, intReq}, 16'h1);
    rd(4'h6, v); chk("R7 flag set", v, 16'hC002);
    wr(4'h6, 16'hC002); cyc(2);
    chk("R7 irq cleared", {15'h0, intReq}, 16'h0);
    rd(4'h6, v); chk("R7 flag cleared", v, 16'h8002);

    // R11 timeout change, R4 broken sequences, R5 expiry
    reqTag = "R11";
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    wr(4'h0, 16'h2034);
    rd(4'h0, v); chk("R11 new field visible", v, 16'h2034);
    tk(2);
    reqTag = "R4";
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    wr(4'h2, 16'hAAAA);
    tk(2); cyc(2);
    reqTag = "R5";
    chk("R4 R5 expiry on old schedule", {15'h0, intRstReq}, 16'h1);
    cyc(10);
    chk("R5 reset held", {15'h0, intRstReq}, 16'h1);
    chk("R5 ext untouched", {15'h0, extRstN}, 16'h1);

    // R8 reset cause
    reqTag = "R8";
    sysReset();
    rd(4'h4, v); chk("R8 cause after timeout", v, 16'h0002);
    chk("R8 reset cleared request", {15'h0, intRstReq}, 16'h0);
    sysReset();
    rd(4'h4, v); chk("R8 cause after plain reset", v, 16'h0000);

    // R6 external path
    reqTag = "R6";
    wr(4'h0, 16'h003C);
    tk(1); cyc(2);
    chk("R6 ext asserted", {15'h0, extRstN}, 16'h0);
    chk("R6 int quiet", {15'h0, intRstReq}, 16'h0);
    cyc(8);
    chk("R6 ext held", {15'h0, extRstN}, 16'h0);
    sysReset();

    // R9 software requests
    reqTag = "R9";
    wr(4'h0, 16'h0020); cyc(1);
    chk("R9 sw internal", {15'h0, intRstReq}, 16'h1);
    wr(4'h0, 16'h0030); cyc(1);
    chk("R9 sw internal released", {15'h0, intRstReq}, 16'h0);
    wr(4'h0, 16'h0010); cyc(1);
    chk("R9 sw external", {15'h0, extRstN}, 16'h0);
    wr(4'h0, 16'h0030); cyc(1);
    chk("R9 sw external released", {15'h0, extRstN}, 16'h1);
    sysReset();
    rd(4'h4, v); chk("R8 R9 software reset not timeout", v, 16'h0000);

    // R10 freeze and write-once
    reqTag = "R10";
    wr(4'h0, 16'h0135);
    lowPower = 1;
    tk(5); cyc(2);
    chk("R10 frozen no expiry", {15'h0, intRstReq}, 16'h0);
    wr(4'h0, 16'h0134);
    rd(4'h0, v); chk("R10 freeze write once", v, 16'h0135);
    lowPower = 0;
    tk(2); cyc(2);
    chk("R10 expiry after thaw", {15'h0, intRstReq}, 16'h1);

    cyc(4);
    summary();
  end
endmodule